// File: doc/BRIEF.md
# DAC Channel Power-Mode Controller

This block keeps the power state of a pair of voltage-output DAC channels and of the bias generator they share. Decoded command strobes arrive from a serial command decoder elsewhere on the chip. These strobes are per-channel shutdown requests, each with a load-select bit, a full power-down request, and per-channel DAC-register load events tagged with their source. From these strobes the block drives, for each channel, an enable flag, a flag that attaches the low-value (1k) termination while the channel is off, and an output-ready flag. It also drives a flag for the shared bias.

A channel shuts down on its own shutdown request or on a full power-down. The load-select bit decides whether the 1k termination is attached or whether only the 200k feedback path remains. Full power-down also switches the bias off. There is no explicit wake command. A channel that is off comes back when its DAC register is reloaded by a serial command, and that wake also restores the bias if it was off. A register load caused by the asynchronous load strobe moves data only and does not wake anything.

Each channel has a down-counter that holds its ready flag low after a wake. The wait is one of two parameters in system clocks. The long wait applies after power-on and after any wake that found the bias off. The short wait applies after a wake from plain channel shutdown.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: While reset is asserted and just after it, every channel is enabled, the bias is on and no 1k termination is attached. Each ready flag stays low for exactly FPD_DLY clock edges after reset is released and then rises.
- R2: A shutdown request on `sd_req[i]` clears `ch_en[i]` at the next edge and leaves the other channels and `bias_en` untouched. Its load-select `sd_hiz[i]` is encoded as 0 = attach the 1k load, so `ch_load_1k[i]` = 1, and 1 = 200k only, so `ch_load_1k[i]` = 0.
- R3: A full power-down request `fpd_req` clears `bias_en` and every `ch_en` at the next edge. It sets each channel's termination from its `sd_hiz` bit with the R2 encoding.
- R4: A serial register load (`reg_load[i]` with `reg_load_ser` = 1) on a disabled channel sets `ch_en[i]` and drops its 1k termination at the next edge. It wakes no other channel.
- R5: A wake per R4 while the bias is off turns `bias_en` back on at the same edge.
- R6: A register load with `reg_load_ser` = 0 (load-strobe source) leaves a disabled channel disabled and the bias unchanged.
- R7: Shutdown requests issued while the bias is off leave the bias off. Only a channel wake restores it.
- R8: After a wake at edge k, `ch_ready[i]` rises at edge k + SD_DLY if the bias was on before the wake and at edge k + FPD_DLY if it was off. It is low whenever the channel is disabled.
- R9: When a shutdown or full power-down and a serial load for the same channel fall in one cycle, the shutdown wins and the channel stays off. A full power-down in that cycle also keeps the bias off.
- R10: A serial load to a channel that is already enabled does not restart its settling wait. A ready channel stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_req | input | NCH | Per-channel shutdown request strobe |
| sd_hiz | input | NCH | Load select for shutdown: 0 = 1k load, 1 = 200k only |
| fpd_req | input | 1 | Full power-down strobe (bias and all channels) |
| reg_load | input | NCH | Per-channel DAC-register load event |
| reg_load_ser | input | 1 | Source of the load: 1 = serial command, 0 = load strobe |
| ch_en | output | NCH | Channel enabled |
| ch_load_1k | output | NCH | 1k termination attached (only while disabled) |
| bias_en | output | 1 | Shared bias generator enabled |
| ch_ready | output | NCH | Channel output settled |

## Verification
A wake and a shutdown aimed at the same channel can arrive in the same clock cycle. A wake of one channel can also coincide with a full power-down. The bench provokes both by pulsing a serial register load together with a shutdown request for a disabled channel, and then together with a full power-down. The reference model applies the rule that shutdown wins. Every clock the bench compares channel enable, termination, bias and ready against the model, so it judges that the channel stays off, that the bias stays off, and that no settling count starts.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;

   // Termination picked when a channel is switched off
   typedef enum logic {
      TERM_1K   = 1'b0,
      TERM_200K = 1'b1
   } term_sel_e;

   // Per-channel decoded command for one cycle
   typedef struct packed {
      logic shut;   // shutdown (own request or full power-down)
      logic hiz;    // load select for this shutdown
      logic upd;    // serial-sourced DAC register load
   } chan_cmd_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_pwr_bias.sv
module dac_pwr_bias #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fpd,
   input  logic [NCH-1:0] wake,
   output logic           bias_o
);

   logic bias_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bias_q <= 1'b1;
      else if (fpd)
         bias_q <= 1'b0;
      else if (|wake)
         bias_q <= 1'b1;
   end

   assign bias_o = bias_q;

endmodule

// File: rtl/dac_pwr_chan.sv
module dac_pwr_chan
   import dac_pwr_pkg::*;
#(
   parameter int SD_DLY  = 50,
   parameter int FPD_DLY = 60,
   parameter int CW      = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  chan_cmd_t cmd,
   input  logic      bias_on,
   output logic      wake_o,
   output logic      en_o,
   output logic      load_1k_o,
   output logic      ready_o
);

   localparam logic [CW-1:0] SHORT_LD = CW'(SD_DLY);
   localparam logic [CW-1:0] LONG_LD  = CW'(FPD_DLY);

   logic            en_q;
   term_sel_e       term_q;
   logic [CW-1:0]   cnt_q;
   logic            wake;

   // Wake only a channel that is off and not being shut this cycle
   assign wake = cmd.upd & ~en_q & ~cmd.shut;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b1;
         term_q <= TERM_200K;
         cnt_q  <= LONG_LD;
      end else if (cmd.shut) begin
         en_q   <= 1'b0;
         term_q <= cmd.hiz ? TERM_200K : TERM_1K;
      end else if (wake) begin
         en_q   <= 1'b1;
         cnt_q  <= bias_on ? SHORT_LD : LONG_LD;
      end else if (en_q && (cnt_q != '0)) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign wake_o    = wake;
   assign en_o      = en_q;
   assign load_1k_o = ~en_q & (term_q == TERM_1K);
   assign ready_o   = en_q & (cnt_q == '0);

endmodule

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl
   import dac_pwr_pkg::*;
#(
   parameter int NCH     = 2,
   parameter int SD_DLY  = 50,
   parameter int FPD_DLY = 60
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] sd_req,
   input  logic [NCH-1:0] sd_hiz,
   input  logic           fpd_req,
   input  logic [NCH-1:0] reg_load,
   input  logic           reg_load_ser,
   output logic [NCH-1:0] ch_en,
   output logic [NCH-1:0] ch_load_1k,
   output logic           bias_en,
   output logic [NCH-1:0] ch_ready
);

   localparam int MAX_DLY = max_of(SD_DLY, FPD_DLY);
   localparam int CW      = $clog2(MAX_DLY + 1);

   // Elaboration-time parameter checks
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("dac_pwr_ctrl: NCH must be at least 1");
      end
      if (SD_DLY < 1 || FPD_DLY < 1) begin : g_bad_dly
         $error("dac_pwr_ctrl: settling delays must be at least 1");
      end
   endgenerate

   logic [NCH-1:0] wake;
   chan_cmd_t      cmd [NCH];

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         assign cmd[i] = '{shut: sd_req[i] | fpd_req,
                           hiz:  sd_hiz[i],
                           upd:  reg_load[i] & reg_load_ser};

         dac_pwr_chan #(
            .SD_DLY  (SD_DLY),
            .FPD_DLY (FPD_DLY),
            .CW      (CW)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[i]),
            .bias_on   (bias_en),
            .wake_o    (wake[i]),
            .en_o      (ch_en[i]),
            .load_1k_o (ch_load_1k[i]),
            .ready_o   (ch_ready[i])
         );
      end
   endgenerate

   dac_pwr_bias #(
      .NCH (NCH)
   ) u_bias (
      .clk    (clk),
      .rst_n  (rst_n),
      .fpd    (fpd_req),
      .wake   (wake),
      .bias_o (bias_en)
   );

endmodule

// File: rtl/dac_pwr_ctrl_chk.sv
module dac_pwr_ctrl_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] sd_req,
   input logic [NCH-1:0] sd_hiz,
   input logic           fpd_req,
   input logic [NCH-1:0] reg_load,
   input logic           reg_load_ser,
   input logic [NCH-1:0] ch_en,
   input logic [NCH-1:0] ch_load_1k,
   input logic           bias_en,
   input logic [NCH-1:0] ch_ready
);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_c
         // R2
         sd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sd_req[i] |=> (!ch_en[i] && (ch_load_1k[i] == !$past(sd_hiz[i]))));

         // R4
         wake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_load[i] && reg_load_ser && !ch_en[i] && !sd_req[i] && !fpd_req)
            |=> (ch_en[i] && !ch_ready[i] && !ch_load_1k[i]));

         // R6
         ldac_nowake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !(reg_load[i] && reg_load_ser)) |=> !ch_en[i]);

         // R10
         ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ready[i] && !sd_req[i] && !fpd_req) |=> ch_ready[i]);
      end
   endgenerate

   // R3
   fpd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fpd_req |=> (!bias_en && (ch_en == '0)));

   // R7
   bias_stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_en && !(|(reg_load & {NCH{reg_load_ser}}))) |=> !bias_en);

   // R5
   bias_revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_en && !fpd_req && reg_load_ser && (|(reg_load & ~ch_en & ~sd_req)))
      |=> bias_en);

endmodule

bind dac_pwr_ctrl dac_pwr_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sd_req       (sd_req),
   .sd_hiz       (sd_hiz),
   .fpd_req      (fpd_req),
   .reg_load     (reg_load),
   .reg_load_ser (reg_load_ser),
   .ch_en        (ch_en),
   .ch_load_1k   (ch_load_1k),
   .bias_en      (bias_en),
   .ch_ready     (ch_ready)
);

// File: tb/dac_pwr_ctrl_bench.sv
module dac_pwr_ctrl_bench;

   localparam int NCH = 2;
   localparam int SD  = 5;
   localparam int FPD = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] sd_req = '0;
   logic [NCH-1:0] sd_hiz = '0;
   logic           fpd_req = 1'b0;
   logic [NCH-1:0] reg_load = '0;
   logic           reg_load_ser = 1'b0;
   logic [NCH-1:0] ch_en, ch_load_1k, ch_ready;
   logic           bias_en;

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_en [NCH];
   int m_t1k[NCH];
   int m_cnt[NCH];
   int m_bias;

   always #5 clk = ~clk;

   dac_pwr_ctrl #(.NCH(NCH), .SD_DLY(SD), .FPD_DLY(FPD)) u_dac_pwr_ctrl (
      .clk(clk), .rst_n(rst_n), .sd_req(sd_req), .sd_hiz(sd_hiz),
      .fpd_req(fpd_req), .reg_load(reg_load), .reg_load_ser(reg_load_ser),
      .ch_en(ch_en), .ch_load_1k(ch_load_1k), .bias_en(bias_en),
      .ch_ready(ch_ready));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_en[i] = 1; m_t1k[i] = 0; m_cnt[i] = FPD;
         end
         m_bias = 1;
      end else begin
         int any_wake;
         int old_bias;
         any_wake = 0;
         old_bias = m_bias;
         for (int i = 0; i < NCH; i++) begin
            if (sd_req[i] || fpd_req) begin
               m_en[i]  = 0;
               m_t1k[i] = sd_hiz[i] ? 0 : 1;
            end else if (reg_load[i] && reg_load_ser && m_en[i] == 0) begin
               m_en[i]  = 1;
               m_cnt[i] = old_bias ? SD : FPD;
               any_wake = 1;
            end else if (m_en[i] == 1 && m_cnt[i] > 0) begin
               m_cnt[i] = m_cnt[i] - 1;
            end
         end
         if (fpd_req) m_bias = 0;
         else if (any_wake) m_bias = 1;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                  cur_req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 1 && !done) begin
         for (int i = 0; i < NCH; i++) begin
            chk($sformatf("ch_en[%0d]", i), int'(ch_en[i]), m_en[i]);
            chk($sformatf("ch_load_1k[%0d]", i), int'(ch_load_1k[i]),
                (m_en[i] == 0 && m_t1k[i] == 1) ? 1 : 0);
            chk($sformatf("ch_ready[%0d]", i), int'(ch_ready[i]),
                (m_en[i] == 1 && m_cnt[i] == 0) ? 1 : 0);
         end
         chk("bias_en", int'(bias_en), m_bias);
      end
   end

   task automatic drive(input string req, input logic [NCH-1:0] sd,
                        input logic [NCH-1:0] hiz, input logic fpd,
                        input logic [NCH-1:0] ld, input logic ser);
      cur_req      = req;
      sd_req       = sd;
      sd_hiz       = hiz;
      fpd_req      = fpd;
      reg_load     = ld;
      reg_load_ser = ser;
      @(negedge clk);
      sd_req = '0; sd_hiz = '0; fpd_req = 1'b0; reg_load = '0; reg_load_ser = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";                            // reset state and power-on wait
      idle(FPD + 4);
      drive("R2", 2'b01, 2'b00, 1'b0, 2'b00, 1'b0); // ch0 off, 1k load
      idle(3);
      drive("R2", 2'b10, 2'b10, 1'b0, 2'b00, 1'b0); // ch1 off, 200k only
      idle(3);
      drive("R4", 2'b00, 2'b00, 1'b0, 2'b01, 1'b1); // serial wake ch0
      cur_req = "R8";
      idle(SD + 3);
      drive("R6", 2'b00, 2'b00, 1'b0, 2'b11, 1'b0); // load strobe: no wake
      idle(3);
      drive("R10", 2'b00, 2'b00, 1'b0, 2'b01, 1'b1); // update enabled ch0
      idle(2);
      drive("R4", 2'b00, 2'b00, 1'b0, 2'b10, 1'b1); // wake ch1
      cur_req = "R8";
      idle(SD + 3);
      drive("R3", 2'b00, 2'b01, 1'b1, 2'b00, 1'b0); // full power-down
      idle(3);
      drive("R7", 2'b11, 2'b00, 1'b0, 2'b00, 1'b0); // shutdown while bias off
      idle(3);
      drive("R6", 2'b00, 2'b00, 1'b0, 2'b11, 1'b0);
      idle(2);
      drive("R9", 2'b10, 2'b00, 1'b0, 2'b10, 1'b1); // wake + shutdown same cycle
      idle(2);
      drive("R9", 2'b00, 2'b11, 1'b1, 2'b01, 1'b1); // wake + full power-down
      idle(2);
      drive("R5", 2'b00, 2'b00, 1'b0, 2'b10, 1'b1); // wake ch1 revives bias
      cur_req = "R8";
      idle(FPD + 3);
      drive("R4", 2'b00, 2'b00, 1'b0, 2'b01, 1'b1); // wake ch0 with bias on
      cur_req = "R8";
      idle(SD + 3);
      drive("R2", 2'b11, 2'b01, 1'b0, 2'b00, 1'b0);
      idle(3);
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         finish_run();
      end
   end

endmodule